// File: doc/BRIEF.md
# Programmable Binary Timer with Tap Select

This block is a 24-stage binary divider-timer for use inside a synchronous design. An external timing input `tin` is brought onto the system clock by a two-flop synchronizer. Each falling edge of that input advances a 24-bit count by one. A hold input can freeze the count. Two static controls force the whole count to zero (`clr`) or to all ones (`fill`). A skip control makes the input drive the upper 16 stages directly, so the lowest 8 stages are bypassed.

A 4-bit tap code picks one of the upper sixteen stages and sends it to `decode_out`. The tapped stage is the same whatever the skip setting. Only the effective divide length changes: 9 to 24 stages without skip, and 1 to 16 stages with skip.

An optional digital one-shot turns each rising edge of the tapped stage into a single pulse. The pulse lasts a programmable number of system clocks, and a new rising edge during the pulse does not restart it.

When skip, fill and clear are all high, the counter enters a split test mode. In that mode the chain becomes three independent 8-bit counters that advance together. A test routine can therefore fill every stage in 255 edges, then return to the series chain and ripple the whole count from all ones to all zeros with one more edge.

The control decode is combinational. Its four modes are:
- RUN: no control is active.
- CLEAR: `clr` is high without the split combination.
- FILL: `fill` is high and `clr` is low.
- SPLIT: `skip8`, `fill` and `clr` are all high.

The one-shot is a two-state machine:
- OS_IDLE moves to OS_PULSE on an enabled rising edge of the tap when the width is non-zero. It loads the width into a down-counter.
- OS_PULSE returns to OS_IDLE when the down-counter reaches one. Otherwise it decrements the counter.

Top module: `prog_timer`

## Requirements
- R1: After system reset, `count_q` is all zeros and `decode_out` is 0.
- R2: In RUN mode with `skip8`=0, each falling edge of `tin` adds one to the 24-bit `count_q`, wrapping from all ones to zero. A rising edge of `tin` changes nothing.
- R3: In RUN mode with `skip8`=1, a falling edge adds one to `count_q[23:8]` and leaves `count_q[7:0]` unchanged.
- R4: With `pulse_en`=0, `decode_out` equals `count_q[8+tap_sel]`. Code k therefore divides the input by 2^(9+k) with `skip8`=0, and by 2^(k+1) with `skip8`=1.
- R5: While `hold` is 1 in RUN or SPLIT mode, falling edges of `tin` leave `count_q` unchanged.
- R6: `clr`=1 without the split combination makes `count_q` all zeros on the next system clock, and it wins over `fill`.
- R7: `fill`=1 with `clr`=0 makes `count_q` all ones on the next system clock.
- R8: With `skip8`, `fill` and `clr` all 1, each falling edge adds one, modulo 256, to each of `count_q[7:0]`, `count_q[15:8]` and `count_q[23:16]` independently. 255 edges from zero give all ones.
- R9: When `fill` and `clr` drop together with `skip8`, the count is kept. The next falling edge then rolls the 24-bit count from all ones to all zeros.
- R10: With `pulse_en`=1 and `pulse_len`=N>0, a rising edge of the selected stage makes `decode_out` high for exactly N consecutive system clocks.
- R11: A rising edge of the selected stage during a pulse neither extends nor restarts it. With `pulse_len`=0, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| tin | input | 1 | External timing input, asynchronous; counts on falling edges |
| hold | input | 1 | Inhibit: freezes the count while high |
| fill | input | 1 | Loads all ones |
| clr | input | 1 | Clears to zero; has priority over `fill` |
| skip8 | input | 1 | Bypasses the lowest 8 stages; with `fill` and `clr` selects split mode |
| tap_sel | input | 4 | Selects stage 8+code for the decode output |
| pulse_en | input | 1 | Routes the one-shot instead of the raw tap to `decode_out` |
| pulse_len | input | 8 | One-shot width in system clocks |
| decode_out | output | 1 | Selected stage, or one-shot pulse |
| count_q | output | 24 | Current state of all stages |

## Verification
The bench runs a long sweep of falling edges from zero with the skip bypass on. After each edge it steps through all sixteen tap codes and compares them with a reference count. This separates a wrong tap index from a wrong divide length. A shorter sweep with the bypass off then shows that the same codes give lengths eight stages longer.

Fill followed by a single edge shows that every tap falls at once, and that the lowest stages are left untouched in bypass. The split sequence checks the parallel byte increments, the joint exit and the full-chain ripple.

The one-shot is tried with three patterns: a single rise, rises spaced closer than the width, and a zero width. Together they separate exact width, retrigger immunity and suppression.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_CLEAR = 2'd1,
        MODE_FILL  = 2'd2,
        MODE_SPLIT = 2'd3
    } mode_e;

    typedef enum logic {
        OS_IDLE  = 1'b0,
        OS_PULSE = 1'b1
    } os_state_e;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Shift register samples the asynchronous input; last_q holds the
    // previous synchronized level for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign fall = last_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/tmr_mode_ctl.sv
module tmr_mode_ctl
    import tmr_pkg::*;
(
    input  logic  skip8,
    input  logic  fill,
    input  logic  clr,
    output mode_e mode
);
    // Split test takes precedence, then clear over fill.
    always_comb begin
        if (skip8 && fill && clr) begin
            mode = MODE_SPLIT;
        end else if (clr) begin
            mode = MODE_CLEAR;
        end else if (fill) begin
            mode = MODE_FILL;
        end else begin
            mode = MODE_RUN;
        end
    end

endmodule

// File: rtl/tmr_chain.sv
module tmr_chain
    import tmr_pkg::*;
#(
    parameter int STAGES = 24,
    parameter int SECT   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic              fall,
    input  logic              hold,
    input  logic              skip8,
    output logic [STAGES-1:0] cnt
);
    localparam int NSECT = STAGES / SECT;
    localparam int HI_W  = STAGES - SECT;
    localparam logic [STAGES-1:0] ONE_FULL = STAGES'(1);
    localparam logic [HI_W-1:0]   ONE_HI   = HI_W'(1);
    localparam logic [SECT-1:0]   ONE_SEC  = SECT'(1);

    logic [STAGES-1:0] cnt_q, cnt_d, split_inc, series_inc;
    logic              step;

    // Independent per-section increment for split test mode.
    generate
        for (genvar s = 0; s < NSECT; s++) begin : g_sect
            assign split_inc[s*SECT +: SECT] = cnt_q[s*SECT +: SECT] + ONE_SEC;
        end
    endgenerate

    // Series increment: full chain, or upper stages only when bypassing.
    always_comb begin
        if (skip8) begin
            series_inc = {cnt_q[STAGES-1:SECT] + ONE_HI, cnt_q[SECT-1:0]};
        end else begin
            series_inc = cnt_q + ONE_FULL;
        end
    end

    assign step = fall & ~hold;

    always_comb begin
        cnt_d = cnt_q;
        unique case (mode)
            MODE_CLEAR: cnt_d = '0;
            MODE_FILL:  cnt_d = '1;
            MODE_SPLIT: if (step) cnt_d = split_inc;
            MODE_RUN:   if (step) cnt_d = series_inc;
            default:    cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/tmr_tap_mux.sv
module tmr_tap_mux #(
    parameter int STAGES = 24,
    parameter int SECT   = 8,
    parameter int SEL_W  = 4
) (
    input  logic [STAGES-1:0] cnt,
    input  logic [SEL_W-1:0]  sel,
    output logic              tap
);
    localparam int TAPS = STAGES - SECT;

    logic [TAPS-1:0] upper;

    assign upper = cnt[STAGES-1:SECT];
    assign tap   = upper[sel];

endmodule

// File: rtl/tmr_oneshot.sv
module tmr_oneshot
    import tmr_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             level,
    input  logic [LEN_W-1:0] len,
    output logic             pulse
);
    localparam logic [LEN_W-1:0] ONE_LEN = LEN_W'(1);

    os_state_e        st_q, st_d;
    logic [LEN_W-1:0] left_q, left_d;
    logic             level_q;
    logic             rise;

    assign rise = en & level & ~level_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= OS_IDLE;
            left_q  <= '0;
            level_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            left_q  <= left_d;
            level_q <= level;
        end
    end

    // Transitions: IDLE->PULSE on an enabled rise with non-zero width,
    // PULSE->IDLE when the remaining count reaches one.
    always_comb begin
        st_d   = st_q;
        left_d = left_q;
        unique case (st_q)
            OS_IDLE: begin
                if (rise && (len != '0)) begin
                    st_d   = OS_PULSE;
                    left_d = len;
                end
            end
            OS_PULSE: begin
                if (left_q == ONE_LEN) begin
                    st_d = OS_IDLE;
                end else begin
                    left_d = left_q - ONE_LEN;
                end
            end
            default: st_d = OS_IDLE;
        endcase
    end

    // Output process.
    always_comb begin
        pulse = (st_q == OS_PULSE);
    end

endmodule

// File: rtl/prog_timer.sv
module prog_timer
    import tmr_pkg::*;
#(
    parameter int STAGES = 24,
    parameter int SECT   = 8,
    parameter int SEL_W  = 4,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tin,
    input  logic              hold,
    input  logic              fill,
    input  logic              clr,
    input  logic              skip8,
    input  logic [SEL_W-1:0]  tap_sel,
    input  logic              pulse_en,
    input  logic [LEN_W-1:0]  pulse_len,
    output logic              decode_out,
    output logic [STAGES-1:0] count_q
);
    mode_e mode;
    logic  fall;
    logic  tap;
    logic  os_pulse;

    tmr_edge_sync #(.SYNC_STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (tin),
        .fall     (fall)
    );

    tmr_mode_ctl u_mode (
        .skip8 (skip8),
        .fill  (fill),
        .clr   (clr),
        .mode  (mode)
    );

    tmr_chain #(.STAGES(STAGES), .SECT(SECT)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .fall  (fall),
        .hold  (hold),
        .skip8 (skip8),
        .cnt   (count_q)
    );

    tmr_tap_mux #(.STAGES(STAGES), .SECT(SECT), .SEL_W(SEL_W)) u_tap (
        .cnt (count_q),
        .sel (tap_sel),
        .tap (tap)
    );

    tmr_oneshot #(.LEN_W(LEN_W)) u_os (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (pulse_en),
        .level (tap),
        .len   (pulse_len),
        .pulse (os_pulse)
    );

    assign decode_out = pulse_en ? os_pulse : tap;

endmodule

// File: rtl/prog_timer_chk.sv
module prog_timer_chk #(
    parameter int STAGES = 24,
    parameter int SECT   = 8,
    parameter int SEL_W  = 4,
    parameter int LEN_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic              fill,
    input logic              clr,
    input logic              skip8,
    input logic              pulse_en,
    input logic [LEN_W-1:0]  pulse_len,
    input logic              decode_out,
    input logic [STAGES-1:0] count_q
);
    localparam logic [STAGES-1:0] ONE_FULL = STAGES'(1);
    localparam logic [LEN_W:0]    ONE_RUN  = (LEN_W+1)'(1);

    logic [LEN_W:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (pulse_en && decode_out) begin
            run_q <= run_q + ONE_RUN;
        end else begin
            run_q <= '0;
        end
    end

    assert_series_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill && !clr && !skip8) |=>
            ((count_q == $past(count_q)) || (count_q == $past(count_q) + ONE_FULL)));

    assert_low_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (skip8 && !fill && !clr) |=> $stable(count_q[SECT-1:0]));

    assert_hold_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !(clr && !(skip8 && fill)) && !(fill && !clr)) |=> $stable(count_q));

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(skip8 && fill)) |=> (count_q == '0));

    assert_fill_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill && !clr) |=> (count_q == '1));

    assert_pulse_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_en && decode_out) |-> (run_q < {1'b0, pulse_len}));

endmodule

bind prog_timer prog_timer_chk #(
    .STAGES (STAGES),
    .SECT   (SECT),
    .SEL_W  (SEL_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .fill       (fill),
    .clr        (clr),
    .skip8      (skip8),
    .pulse_en   (pulse_en),
    .pulse_len  (pulse_len),
    .decode_out (decode_out),
    .count_q    (count_q)
);

// File: tb/prog_timer_tb_top.sv
module prog_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tin = 1'b0;
    logic        hold = 1'b0;
    logic        fill = 1'b0;
    logic        clr = 1'b0;
    logic        skip8 = 1'b0;
    logic [3:0]  tap_sel = 4'd0;
    logic        pulse_en = 1'b0;
    logic [7:0]  pulse_len = 8'd0;
    logic        decode_out;
    logic [23:0] count_q;

    int total = 0;
    int bad = 0;
    int hi_cnt = 0;
    bit mon_on = 1'b0;
    logic [23:0] model = '0;

    always #5 clk = ~clk;

    prog_timer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tin        (tin),
        .hold       (hold),
        .fill       (fill),
        .clr        (clr),
        .skip8      (skip8),
        .tap_sel    (tap_sel),
        .pulse_en   (pulse_en),
        .pulse_len  (pulse_len),
        .decode_out (decode_out),
        .count_q    (count_q)
    );

    always @(negedge clk) begin
        if (mon_on && decode_out) hi_cnt = hi_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One full input period ending with a falling edge.
    task automatic pulse_tin();
        @(negedge clk); tin = 1'b1;
        wait_n(3);
        tin = 1'b0;
        wait_n(4);
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        wait_n(2);
        clr = 1'b0;
        wait_n(1);
        model = '0;
    endtask

    task automatic t_reset();
        chk(count_q == 24'd0, "R1 count", int'(count_q), 0);
        chk(decode_out == 1'b0, "R1 decode", int'(decode_out), 0);
    endtask

    task automatic t_run_basic();
        do_clear();
        skip8 = 1'b0;
        @(negedge clk); tin = 1'b1;
        wait_n(5);
        chk(count_q == 24'd0, "R2 rise no step", int'(count_q), 0);
        tin = 1'b0;
        wait_n(4);
        chk(count_q == 24'd1, "R2 first fall", int'(count_q), 1);
        for (int i = 0; i < 6; i++) pulse_tin();
        chk(count_q == 24'd7, "R2 seven falls", int'(count_q), 7);
    endtask

    task automatic t_hold();
        do_clear();
        hold = 1'b1;
        for (int i = 0; i < 3; i++) pulse_tin();
        chk(count_q == 24'd0, "R5 held", int'(count_q), 0);
        hold = 1'b0;
        pulse_tin();
        chk(count_q == 24'd1, "R5 released", int'(count_q), 1);
    endtask

    task automatic t_set_clear();
        @(negedge clk); fill = 1'b1;
        wait_n(2);
        chk(count_q == 24'hFFFFFF, "R7 fill", int'(count_q), 24'hFFFFFF);
        clr = 1'b1;
        wait_n(2);
        chk(count_q == 24'd0, "R6 clear wins", int'(count_q), 0);
        fill = 1'b0;
        clr = 1'b0;
        wait_n(1);
        chk(count_q == 24'd0, "R6 stays clear", int'(count_q), 0);
    endtask

    task automatic t_bypass_and_wrap();
        // All taps high after fill, all low after one edge.
        @(negedge clk); fill = 1'b1;
        wait_n(2);
        fill = 1'b0;
        wait_n(1);
        for (int k = 0; k < 16; k++) begin
            tap_sel = 4'(k); #1;
            chk(decode_out == 1'b1, "R4 tap high after fill", int'(decode_out), 1);
        end
        skip8 = 1'b1;
        pulse_tin();
        chk(count_q == 24'h0000FF, "R3 low byte kept", int'(count_q), 24'h0000FF);
        for (int k = 0; k < 16; k++) begin
            tap_sel = 4'(k); #1;
            chk(decode_out == 1'b0, "R4 tap low after wrap", int'(decode_out), 0);
        end
        skip8 = 1'b0;
        wait_n(1);
    endtask

    task automatic sweep(input bit byp, input int edges);
        do_clear();
        skip8 = byp;
        for (int e = 0; e < edges; e++) begin
            pulse_tin();
            if (byp) model = {model[23:8] + 16'd1, model[7:0]};
            else     model = model + 24'd1;
            if (byp && (count_q[7:0] != 8'd0)) begin
                chk(1'b0, "R3 low byte moved", int'(count_q), int'(model));
            end
            for (int k = 0; k < 16; k++) begin
                tap_sel = 4'(k); #1;
                chk(decode_out == model[8+k], "R4 tap divide", int'(decode_out), int'(model[8+k]));
            end
        end
        chk(count_q == model, "R4 sweep count", int'(count_q), int'(model));
        skip8 = 1'b0;
    endtask

    task automatic t_split();
        do_clear();
        @(negedge clk);
        skip8 = 1'b1; fill = 1'b1; clr = 1'b1;
        wait_n(2);
        chk(count_q == 24'd0, "R8 entry keeps", int'(count_q), 0);
        pulse_tin();
        chk(count_q == 24'h010101, "R8 parallel step", int'(count_q), 24'h010101);
        for (int i = 1; i < 255; i++) pulse_tin();
        chk(count_q == 24'hFFFFFF, "R8 all ones", int'(count_q), 24'hFFFFFF);
        @(negedge clk);
        skip8 = 1'b0; fill = 1'b0; clr = 1'b0;
        wait_n(2);
        chk(count_q == 24'hFFFFFF, "R9 exit keeps", int'(count_q), 24'hFFFFFF);
        pulse_tin();
        chk(count_q == 24'd0, "R9 ripple to zero", int'(count_q), 0);
    endtask

    task automatic t_oneshot();
        pulse_en = 1'b1;
        pulse_len = 8'd5;
        skip8 = 1'b1;
        tap_sel = 4'd0;
        do_clear();
        @(negedge clk); hi_cnt = 0; mon_on = 1'b1;
        pulse_tin();
        wait_n(20);
        mon_on = 1'b0;
        chk(hi_cnt == 5, "R10 width", hi_cnt, 5);
    endtask

    task automatic t_retrigger();
        pulse_len = 8'd40;
        do_clear();
        @(negedge clk); hi_cnt = 0; mon_on = 1'b1;
        for (int i = 0; i < 3; i++) pulse_tin();
        wait_n(50);
        mon_on = 1'b0;
        chk(hi_cnt == 40, "R11 no retrigger", hi_cnt, 40);
        pulse_len = 8'd0;
        do_clear();
        @(negedge clk); hi_cnt = 0; mon_on = 1'b1;
        pulse_tin();
        wait_n(10);
        mon_on = 1'b0;
        chk(hi_cnt == 0, "R11 zero width", hi_cnt, 0);
        pulse_en = 1'b0;
        skip8 = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_n(3);
        t_reset();
        rst_n = 1'b1;
        wait_n(2);
        t_reset();
        t_run_basic();
        t_hold();
        t_set_clear();
        t_bypass_and_wrap();
        sweep(1'b1, 4096);
        sweep(1'b0, 600);
        t_split();
        t_oneshot();
        t_retrigger();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule